// File: doc/BRIEF.md
# Two-Step Register Write Unlock

This block protects a clock and control register space from stray writes. It sits behind a serial-bus front end that has already decoded the bit stream. The front end reports each bus event as a one-cycle pulse: a transaction start together with its device byte, the register address byte, each data byte, a stop, or an abort. The block holds two volatile latches, a write-enable latch and a register-write-enable latch. It passes a write on to the clock area (SRAM) or to the non-volatile control area only when both latches are set. Writes to the status location never go out; they drive the latches.

Software opens the space with two status writes in a fixed order. The first value arms the write-enable latch. The second value sets the register-write-enable latch as well. A completed write to the clock or control area closes the register-write-enable latch again. An aborted transaction leaves it open. A completed control-area write starts a busy period of `BUSY_CYCLES` clocks, and the block ignores every write that arrives during that period.

Top module: `reg_write_guard`

## Requirements
- R1: After reset, `wel`, `rwel`, `busy` and `wr_en` are all low.
- R2: Writing 8'h02 to the status address (default 8'h3F) sets `wel` and leaves `rwel` unchanged.
- R3: Writing 8'h06 to the status address sets both `rwel` and `wel`, but only when `wel` is already set. 8'h06 written with `wel` clear has no effect, and other nonzero values (for example 8'h04) never set `rwel`.
- R4: Writing 8'h00 to the status address clears both `wel` and `rwel`.
- R5: With both latches set, data bytes of a transaction that starts in the clock area (default 8'h30 to 8'h37) are forwarded, one cycle after each byte, on `wr_en` with `wr_area` = 1, the incrementing address and the data. Bytes that run past the last of the 8 locations are dropped.
- R6: With both latches set, a transaction that starts in the control area (default 8'h10 to 8'h14) forwards one to five bytes with `wr_area` = 2. Bytes past the fifth location are dropped.
- R7: No byte is forwarded unless both `wel` and `rwel` are set when it arrives.
- R8: A stop that ends a transaction which forwarded at least one byte clears `rwel` and keeps `wel`.
- R9: An abort does not change `wel` or `rwel`.
- R10: Read transactions (device byte 8'hDF) placed between the two unlock writes do not change the latches or break the sequence.
- R11: A write to an undefined address forwards nothing, and its stop leaves `rwel` set.
- R12: A stop after a forwarded control-area write raises `busy` for exactly `BUSY_CYCLES` cycles. A clock-area write raises no busy period.
- R13: While `busy` is high, every data byte is ignored, including status writes.
- R14: A transaction whose device byte is not 8'hDE (device 1101111, write bit 0) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Transaction start pulse |
| bus_dev | input | 8 | Device byte, valid with `bus_start` |
| bus_addr_vld | input | 1 | `bus_byte` carries the register address |
| bus_data_vld | input | 1 | `bus_byte` carries a data byte |
| bus_byte | input | 8 | Address or data byte |
| bus_stop | input | 1 | Transaction completed with a stop |
| bus_abort | input | 1 | Transaction aborted |
| wr_en | output | 1 | Forwarded write strobe |
| wr_area | output | 2 | 1 = clock area, 2 = control area |
| wr_addr | output | 8 | Forwarded register address |
| wr_data | output | 8 | Forwarded data byte |
| wel | output | 1 | Write-enable latch |
| rwel | output | 1 | Register-write-enable latch |
| busy | output | 1 | Non-volatile write in progress |

## Verification
Some properties hold on every cycle, and the assertions check them continuously. `rwel` is never set without `wel`. A forwarded write always follows a cycle in which both latches were set and the block was not busy. `rwel` only rises after a data byte of 8'h06. `busy` only rises after a stop. An abort leaves both latches unchanged. Other behaviour needs whole transactions, so only the bench scenarios can show it: the exact set of bytes forwarded at the area limits, that reads between the unlock steps leave the sequence intact, that a write to an undefined address leaves the unlock in place, that the busy period has the right length, and that status writes are ignored while busy.

// File: rtl/reg_write_guard.sv
module reg_write_guard #(
  parameter logic [7:0] DEV_WRITE   = 8'hDE,
  parameter logic [7:0] SR_ADDR     = 8'h3F,
  parameter logic [7:0] RTC_BASE    = 8'h30,
  parameter int         RTC_BYTES   = 8,
  parameter logic [7:0] CTL_BASE    = 8'h10,
  parameter int         CTL_BYTES   = 5,
  parameter int         BUSY_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_start,
  input  logic [7:0] bus_dev,
  input  logic       bus_addr_vld,
  input  logic       bus_data_vld,
  input  logic [7:0] bus_byte,
  input  logic       bus_stop,
  input  logic       bus_abort,
  output logic       wr_en,
  output logic [1:0] wr_area,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       wel,
  output logic       rwel,
  output logic       busy
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [1:0] AR_NONE = 2'd0, AR_RTC = 2'd1, AR_CTL = 2'd2, AR_SR = 2'd3;
  localparam logic [8:0] RTC_END = 9'(int'(RTC_BASE) + RTC_BYTES);
  localparam logic [8:0] CTL_END = 9'(int'(CTL_BASE) + CTL_BYTES);

  function automatic logic [1:0] area_of(input logic [7:0] a);
    logic [8:0] w;
    w = {1'b0, a};
    if (a == SR_ADDR)                                 return AR_SR;
    else if (w >= {1'b0, RTC_BASE} && w < RTC_END)    return AR_RTC;
    else if (w >= {1'b0, CTL_BASE} && w < CTL_END)    return AR_CTL;
    else                                              return AR_NONE;
  endfunction

  logic          txn_on, addr_ok, hit_mem, hit_ctl;
  logic [7:0]    ptr;
  logic [1:0]    first_ar, cur_ar;
  logic [CW-1:0] cnt;
  logic          take, sr_wr, mem_wr;

  assign busy   = cnt != '0;
  assign cur_ar = area_of(ptr);
  assign take   = bus_data_vld && txn_on && addr_ok && !busy;
  assign sr_wr  = take && cur_ar == first_ar && cur_ar == AR_SR;
  assign mem_wr = take && cur_ar == first_ar && (cur_ar == AR_RTC || cur_ar == AR_CTL)
                  && wel && rwel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txn_on <= 1'b0; addr_ok <= 1'b0; hit_mem <= 1'b0; hit_ctl <= 1'b0;
      ptr <= '0; first_ar <= AR_NONE; cnt <= '0;
      wel <= 1'b0; rwel <= 1'b0;
      wr_en <= 1'b0; wr_area <= AR_NONE; wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_en <= mem_wr;
      if (mem_wr) begin
        wr_area <= cur_ar;
        wr_addr <= ptr;
        wr_data <= bus_byte;
      end
      if (busy) cnt <= cnt - CW'(1);

      if (bus_start) begin
        txn_on  <= bus_dev == DEV_WRITE;
        addr_ok <= 1'b0;
        hit_mem <= 1'b0;
        hit_ctl <= 1'b0;
      end else if (bus_stop || bus_abort) begin
        txn_on  <= 1'b0;
        addr_ok <= 1'b0;
        if (bus_stop && txn_on && hit_mem) rwel <= 1'b0;
        if (bus_stop && txn_on && hit_ctl) cnt  <= CW'(BUSY_CYCLES);
      end else if (bus_addr_vld && txn_on && !addr_ok) begin
        ptr      <= bus_byte;
        first_ar <= area_of(bus_byte);
        addr_ok  <= 1'b1;
      end else if (bus_data_vld && txn_on && addr_ok) begin
        ptr <= ptr + 8'd1;
        if (mem_wr) begin
          hit_mem <= 1'b1;
          if (cur_ar == AR_CTL) hit_ctl <= 1'b1;
        end
        if (sr_wr) begin
          case (bus_byte)
            8'h00: begin wel <= 1'b0; rwel <= 1'b0; end
            8'h02: wel <= 1'b1;
            8'h06: if (wel) rwel <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  assert_rwel_implies_wel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rwel |-> wel);
  assert_rwel_rise_on_06_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rwel) |-> $past(bus_data_vld && bus_byte == 8'h06));
  assert_fwd_needs_unlock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(wel && rwel));
  assert_fwd_not_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(!busy));
  assert_busy_after_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_stop));
  assert_abort_keeps_latches_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_abort |=> $stable(rwel) && $stable(wel));
  assert_area_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_area == AR_RTC || wr_area == AR_CTL));
endmodule

// File: tb/test_reg_write_guard.sv
module test_reg_write_guard;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_start = 1'b0, bus_addr_vld = 1'b0, bus_data_vld = 1'b0;
  logic       bus_stop = 1'b0, bus_abort = 1'b0;
  logic [7:0] bus_dev = '0, bus_byte = '0;
  logic       wr_en, wel, rwel, busy;
  logic [1:0] wr_area;
  logic [7:0] wr_addr, wr_data;

  int checks = 0, errors = 0;
  logic [17:0] exp_q[$];
  string       req_q[$];

  reg_write_guard #(.BUSY_CYCLES(30)) i_reg_write_guard (
    .clk, .rst_n, .bus_start, .bus_dev, .bus_addr_vld, .bus_data_vld, .bus_byte,
    .bus_stop, .bus_abort, .wr_en, .wr_area, .wr_addr, .wr_data, .wel, .rwel, .busy);

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_q.size() == 0) check(0, "R7 unexpected write", {wr_area, wr_addr, wr_data}, 0);
      else begin
        logic [17:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check({wr_area, wr_addr, wr_data} == e, r, {wr_area, wr_addr, wr_data}, e);
      end
    end
  end

  task automatic ev_start(input logic [7:0] dev);
    @(negedge clk); bus_start = 1'b1; bus_dev = dev;
    @(negedge clk); bus_start = 1'b0;
  endtask
  task automatic ev_byte(input bit is_addr, input logic [7:0] b);
    @(negedge clk); bus_byte = b; bus_addr_vld = is_addr; bus_data_vld = !is_addr;
    @(negedge clk); bus_addr_vld = 1'b0; bus_data_vld = 1'b0;
  endtask
  task automatic ev_end(input bit stop);
    @(negedge clk); bus_stop = stop; bus_abort = !stop;
    @(negedge clk); bus_stop = 1'b0; bus_abort = 1'b0;
  endtask

  task automatic txn(input logic [7:0] dev, input logic [7:0] a, input int n,
                     input logic [7:0] d0, input int n_ok, input logic [1:0] ar,
                     input bit stop, input string req);
    ev_start(dev);
    ev_byte(1'b1, a);
    for (int i = 0; i < n; i++) begin
      if (i < n_ok) begin
        exp_q.push_back({ar, 8'(a + i), 8'(d0 + i)});
        req_q.push_back(req);
      end
      ev_byte(1'b0, 8'(d0 + i));
    end
    ev_end(stop);
  endtask

  task automatic sr_write(input logic [7:0] v);
    txn(8'hDE, 8'h3F, 1, v, 0, 2'd0, 1'b1, "status");
  endtask

  task automatic drained(input string req);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check({wel, rwel, busy, wr_en} == 4'b0, "R1 reset", {wel, rwel, busy, wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({wel, rwel, busy, wr_en} == 4'b0, "R1 after reset", {wel, rwel, busy, wr_en}, 0);

    txn(8'hDE, 8'h30, 2, 8'h11, 0, 2'd1, 1'b1, "R7");
    drained("R7 locked write dropped");
    sr_write(8'h06);
    check(!wel && !rwel, "R3 06 without wel", {wel, rwel}, 0);
    sr_write(8'h02);
    check(wel && !rwel, "R2 02 sets wel only", {wel, rwel}, 2);
    sr_write(8'h04);
    check(wel && !rwel, "R3 04 leaves rwel", {wel, rwel}, 2);
    txn(8'hDE, 8'h31, 1, 8'h22, 0, 2'd1, 1'b1, "R7");
    drained("R7 wel alone not enough");

    txn(8'hDF, 8'h3F, 1, 8'h00, 0, 2'd0, 1'b1, "R10");
    check(wel && !rwel, "R10 read keeps wel", {wel, rwel}, 2);
    sr_write(8'h06);
    check(wel && rwel, "R10 R3 unlock after read", {wel, rwel}, 3);

    txn(8'hDE, 8'h32, 2, 8'h40, 2, 2'd1, 1'b0, "R5");
    drained("R5 bytes before abort");
    check(wel && rwel, "R9 abort keeps latches", {wel, rwel}, 3);

    txn(8'hDE, 8'h50, 1, 8'h55, 0, 2'd0, 1'b1, "R11");
    drained("R11 undefined address");
    check(rwel, "R11 rwel kept", rwel, 1);

    txn(8'hA0, 8'h30, 1, 8'h66, 0, 2'd1, 1'b1, "R14");
    drained("R14 wrong device");
    check(rwel, "R14 rwel kept", rwel, 1);

    txn(8'hDE, 8'h30, 10, 8'hA0, 8, 2'd1, 1'b1, "R5");
    drained("R5 clock area limit");
    check(wel && !rwel, "R8 stop clears rwel", {wel, rwel}, 2);
    check(!busy, "R12 clock write no busy", busy, 0);

    sr_write(8'h06);
    sr_write(8'h00);
    check(!wel && !rwel, "R4 00 clears both", {wel, rwel}, 0);
    sr_write(8'h02);
    sr_write(8'h06);
    check(wel && rwel, "R3 unlock", {wel, rwel}, 3);

    txn(8'hDE, 8'h10, 6, 8'hC0, 5, 2'd2, 1'b1, "R6");
    check(busy, "R12 busy after control write", busy, 1);
    check(!rwel, "R8 control stop clears rwel", rwel, 0);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
    check(n == 30, "R12 busy length", n, 30);
    drained("R6 control area limit");

    sr_write(8'h02);
    sr_write(8'h06);
    txn(8'hDE, 8'h14, 1, 8'h77, 1, 2'd2, 1'b1, "R6");
    check(busy, "R12 single control byte", busy, 1);
    sr_write(8'h00);
    check(wel && busy, "R13 status ignored while busy", {wel, busy}, 3);
    while (busy) @(negedge clk);
    sr_write(8'h00);
    check(!wel, "R13 R4 status works after busy", wel, 0);
    drained("R6 single byte");

    summary();
  end
endmodule